// File: doc/BRIEF.md
# SPI Flash Read and Byte-Program Controller

This block is the host end of a serial flash link. A client hands it one command at a time: either a burst read of any number of bytes starting from a 24-bit address, or a single-byte program. The controller turns the command into framed SPI transactions. It drives the serial clock in mode 0 and the active-low chip enable, shifts opcodes and addresses out most significant bit first, and collects the returned bits on the rising clock edge.

A read is one frame. It holds chip enable low for the whole burst and relies on the device to advance its own address. Each byte is handed to the client over a valid/ready pair. The serial clock stops while a byte waits to be taken, so a slow consumer never loses data.

A program is three kinds of frame. First comes a write-enable frame, then the program frame with address and data, and then repeated status reads until the device reports idle. A poll limit supplied with the command bounds the status reads. When the limit is used up, the command ends with an error. Every frame is followed by a minimum chip-enable-high interval, and completion is signalled only after that interval.

Top module: `spi_flash_ctrl`

## Requirements
- R1: While reset is held and after it, chip enable is high (1), the serial clock is low, cmd_ready is high, and rd_valid, done and err are low.
- R2: Serial timing is mode 0. The serial clock is low whenever chip enable is high, and each high phase lasts exactly CLK_DIV clock cycles. si changes only while the serial clock is low. Every byte goes out MSB first.
- R3: A read (cmd_op = 0) is one chip-enable frame. The frame carries opcode 03h, then address bits 23..16, 15..8 and 7..0, then exactly cmd_len data bytes. With cmd_len = 0 the frame ends after the address. The k-th byte delivered is the device byte at start address + k.
- R4: A read byte stays on rd_data with rd_valid high and unchanged until rd_ready is seen. The serial clock stays low while a byte is held.
- R5: A program (cmd_op = 1) first sends a one-byte frame holding 06h. It then sends a five-byte frame: 02h, the three address bytes high to low, and cmd_wdata.
- R6: After the program frame, the controller sends status frames of two bytes (05h, then one byte clocked in). It repeats them until bit 0 of the returned byte is 0, and then completes with err = 0.
- R7: If cmd_poll_limit status frames have all returned bit 0 = 1, the command completes with err = 1 and no further frame is sent. A limit of 0 acts as 1.
- R8: Chip enable stays high for at least CS_GAP*2*CLK_DIV clock cycles between frames and before done.
- R9: A command is taken when cmd_valid and cmd_ready are both high. cmd_ready is high only while no command is in progress. done is a one-cycle pulse, and err is high only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command may be taken |
| cmd_op | input | 1 | 0 = burst read, 1 = byte program |
| cmd_addr | input | 24 | Start address |
| cmd_len | input | CNT_W | Number of bytes to read |
| cmd_wdata | input | 8 | Byte to program |
| cmd_poll_limit | input | TMO_W | Maximum status frames for a program |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| done | output | 1 | Command finished (pulse) |
| err | output | 1 | Status poll limit reached (with done) |
| sck | output | 1 | Serial clock, idles low |
| ce_n | output | 1 | Chip enable, active low |
| si | output | 1 | Serial data to the device |
| so | input | 1 | Serial data from the device |

## Verification
The hardest cases to reach from the ports are the end of the status loop and a consumer stall in the middle of a burst. The first depends on how many times the device reports busy. The second depends on the consumer holding back while the serial clock would otherwise run. The bench contains a behavioural flash model whose busy indication lasts a chosen number of status frames. Programs are run with busy counts below, equal to and above the poll limit, and with a limit of zero. Reads are swept over lengths 0 to 6 at several start addresses, one of them near the wrapping end of the model array. Each sweep runs under three consumer patterns, one of which keeps rd_ready low for twenty cycles on every byte.

// File: rtl/sfc_pkg.sv
// Package: shared types and protocol constants for the serial flash controller.
// Assumes a 24-bit address space and single-bit serial data lines.
package sfc_pkg;
    localparam int ADDR_W = 24;

    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_PROG  = 8'h02;
    localparam logic [7:0] OPC_WREN  = 8'h06;
    localparam logic [7:0] OPC_STAT  = 8'h05;

    // Which frame kind the sequencer is currently building.
    typedef enum logic [1:0] {
        PH_WREN = 2'd0,
        PH_PROG = 2'd1,
        PH_POLL = 2'd2,
        PH_READ = 2'd3
    } phase_t;

    // Sequencer states.
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_START = 3'd1,
        S_SEND  = 3'd2,
        S_WAIT  = 3'd3,
        S_HOLD  = 3'd4,
        S_GAP   = 3'd5
    } state_t;
endpackage

// File: rtl/sfc_tick_gen.sv
// Module: sfc_tick_gen
// Produces a one-cycle tick every DIV clock cycles while run is high.
// Assumes DIV >= 1. The count restarts from zero whenever run drops,
// so the first tick always comes DIV cycles after run rises.
module sfc_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Free-running divider count, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/sfc_byte_shifter.sv
// Module: sfc_byte_shifter
// Moves one byte in each direction over a mode-0 serial link: the clock idles
// low, si is updated while the clock is low, and so is captured on the
// rising edge. Bits travel MSB first. start is honoured only while idle;
// done pulses once, with rx holding the received byte, after the eighth
// falling edge. Assumes the caller frames chip enable around the bytes.
module sfc_byte_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       so,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx,
    output logic       sck,
    output logic       si
);
    logic       tick;
    logic [7:0] out_q;
    logic [7:0] in_q;
    logic [3:0] rises;

    sfc_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .tick (tick)
    );

    // Bit sequencing: load on start, toggle the clock on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            sck   <= 1'b0;
            si    <= 1'b0;
            out_q <= '0;
            in_q  <= '0;
            rises <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                si    <= tx[7];
                out_q <= {tx[6:0], 1'b0};
                rises <= '0;
            end else if (busy && tick) begin
                if (!sck) begin
                    sck   <= 1'b1;
                    in_q  <= {in_q[6:0], so};
                    rises <= rises + 1'b1;
                end else begin
                    sck <= 1'b0;
                    if (rises == 4'd8) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        si    <= out_q[7];
                        out_q <= {out_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign rx = in_q;

    // R2: data to the device never moves while the clock is high.
    p_si_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> $stable(si));
endmodule

// File: rtl/spi_flash_ctrl.sv
// Module: spi_flash_ctrl
// Host-side serial flash controller for burst reads and single-byte programs.
// A read is a single chip-enable frame of unbounded length. A program is a
// write-enable frame, a program frame, and status frames repeated until the
// busy bit (bit 0) clears or the poll limit is used up. Assumes the device
// advances its address on its own during a read and that one command is
// outstanding at a time. Each frame is followed by a chip-enable-high
// interval of CS_GAP serial clock periods.
module spi_flash_ctrl
    import sfc_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int CS_GAP  = 4,
    parameter int CNT_W   = 16,
    parameter int TMO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_len,
    input  logic [7:0]        cmd_wdata,
    input  logic [TMO_W-1:0]  cmd_poll_limit,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              done,
    output logic              err,
    output logic              sck,
    output logic              ce_n,
    output logic              si,
    input  logic              so
);
    localparam int GAPC = CS_GAP * 2 * CLK_DIV;
    localparam int GW   = $clog2(GAPC + 1);

    state_t            state;
    phase_t            phase;
    logic [2:0]        idx;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem;
    logic [7:0]        wdata_q;
    logic [TMO_W-1:0]  limit_q;
    logic [TMO_W-1:0]  poll_cnt;
    logic [TMO_W:0]    poll_next;
    logic              stat_busy;
    logic [GW-1:0]     gap_cnt;

    logic              eng_start;
    logic              eng_busy;
    logic              eng_done;
    logic [7:0]        eng_rx;
    logic [7:0]        tx_byte;

    sfc_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .start(eng_start),
        .tx   (tx_byte),
        .so   (so),
        .busy (eng_busy),
        .done (eng_done),
        .rx   (eng_rx),
        .sck  (sck),
        .si   (si)
    );

    // Byte to send, chosen by frame kind and position within the frame.
    always_comb begin
        tx_byte = 8'h00;
        unique case (phase)
            PH_WREN: tx_byte = OPC_WREN;
            PH_POLL: tx_byte = (idx == 3'd0) ? OPC_STAT : 8'h00;
            PH_PROG, PH_READ: begin
                case (idx)
                    3'd0:    tx_byte = (phase == PH_PROG) ? OPC_PROG : OPC_READ;
                    3'd1:    tx_byte = addr_q[23:16];
                    3'd2:    tx_byte = addr_q[15:8];
                    3'd3:    tx_byte = addr_q[7:0];
                    default: tx_byte = (phase == PH_PROG) ? wdata_q : 8'h00;
                endcase
            end
            default: tx_byte = 8'h00;
        endcase
    end

    assign eng_start = (state == S_SEND) && !eng_busy;
    assign cmd_ready = (state == S_IDLE);
    assign poll_next = {1'b0, poll_cnt} + 1'b1;

    // Command sequencer: frames, inter-frame gap, polling and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            phase     <= PH_READ;
            idx       <= '0;
            addr_q    <= '0;
            rem       <= '0;
            wdata_q   <= '0;
            limit_q   <= '0;
            poll_cnt  <= '0;
            stat_busy <= 1'b0;
            gap_cnt   <= '0;
            ce_n      <= 1'b1;
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        addr_q  <= cmd_addr;
                        rem     <= cmd_len;
                        wdata_q <= cmd_wdata;
                        limit_q <= cmd_poll_limit;
                        phase   <= cmd_op ? PH_WREN : PH_READ;
                        state   <= S_START;
                    end
                end
                S_START: begin
                    ce_n  <= 1'b0;
                    idx   <= '0;
                    state <= S_SEND;
                end
                S_SEND: begin
                    if (!eng_busy) begin
                        state <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (eng_done) begin
                        if (idx != 3'd4) begin
                            idx <= idx + 1'b1;
                        end
                        state <= S_SEND;
                        unique case (phase)
                            PH_READ: begin
                                if (idx == 3'd4) begin
                                    rd_data  <= eng_rx;
                                    rd_valid <= 1'b1;
                                    rem      <= rem - 1'b1;
                                    state    <= S_HOLD;
                                end else if (idx == 3'd3 && rem == '0) begin
                                    state   <= S_GAP;
                                    ce_n    <= 1'b1;
                                    gap_cnt <= GW'(GAPC - 1);
                                end
                            end
                            PH_POLL: begin
                                if (idx == 3'd1) begin
                                    stat_busy <= eng_rx[0];
                                    state     <= S_GAP;
                                    ce_n      <= 1'b1;
                                    gap_cnt   <= GW'(GAPC - 1);
                                end
                            end
                            PH_PROG: begin
                                if (idx == 3'd4) begin
                                    state   <= S_GAP;
                                    ce_n    <= 1'b1;
                                    gap_cnt <= GW'(GAPC - 1);
                                end
                            end
                            default: begin
                                state   <= S_GAP;
                                ce_n    <= 1'b1;
                                gap_cnt <= GW'(GAPC - 1);
                            end
                        endcase
                    end
                end
                S_HOLD: begin
                    if (rd_ready) begin
                        rd_valid <= 1'b0;
                        if (rem == '0) begin
                            state   <= S_GAP;
                            ce_n    <= 1'b1;
                            gap_cnt <= GW'(GAPC - 1);
                        end else begin
                            state <= S_SEND;
                        end
                    end
                end
                S_GAP: begin
                    if (gap_cnt != '0) begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end else begin
                        unique case (phase)
                            PH_WREN: begin
                                phase <= PH_PROG;
                                state <= S_START;
                            end
                            PH_PROG: begin
                                phase    <= PH_POLL;
                                poll_cnt <= '0;
                                state    <= S_START;
                            end
                            PH_POLL: begin
                                if (!stat_busy) begin
                                    done  <= 1'b1;
                                    state <= S_IDLE;
                                end else if (poll_next >= {1'b0, limit_q}) begin
                                    done  <= 1'b1;
                                    err   <= 1'b1;
                                    state <= S_IDLE;
                                end else begin
                                    poll_cnt <= poll_next[TMO_W-1:0];
                                    state    <= S_START;
                                end
                            end
                            default: begin
                                done  <= 1'b1;
                                state <= S_IDLE;
                            end
                        endcase
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: the serial clock rests low outside a frame.
    p_ce_idle_sck_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> !sck);

    // R4: an unaccepted byte stays put.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R4: no clocking while a byte is waiting for the consumer.
    p_no_sck_in_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !sck);

    // R7: the error flag only accompanies completion.
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R9: completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: after completion the controller is ready again.
    p_done_then_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);
endmodule

// File: tb/spi_flash_ctrl_tb.sv
// Bench for spi_flash_ctrl with a small behavioural flash model.
module spi_flash_ctrl_tb;
    localparam int CLK_DIV = 2;
    localparam int CS_GAP  = 2;
    localparam int GAP_MIN = CS_GAP * 2 * CLK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_op = 1'b0;
    logic [23:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic [7:0]  cmd_wdata = '0;
    logic [15:0] cmd_poll_limit = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic        done;
    logic        err;
    logic        sck;
    logic        ce_n;
    logic        si;
    logic        so_r = 1'b0;

    int total = 0;
    int fails = 0;

    spi_flash_ctrl #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_wdata(cmd_wdata), .cmd_poll_limit(cmd_poll_limit),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .done(done), .err(err), .sck(sck), .ce_n(ce_n), .si(si), .so(so_r)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- flash model (edges detected at the falling clk edge)
    logic [7:0]  mem [64];
    int          busy_init = 0;
    int          busy_left = 0;
    logic        ce_q = 1'b1;
    logic        sck_q = 1'b0;
    int          bcnt = 0;
    int          nby = 0;
    logic [7:0]  sh = '0;
    logic [7:0]  opc = '0;
    logic [7:0]  outb = '0;
    logic [7:0]  pdat = '0;
    logic [23:0] fa = '0;
    logic [5:0]  rp = '0;
    logic        wel = 1'b0;
    int          fr_n = 0;
    logic [7:0]  fr_op [64];
    int          fr_nb [64];
    logic [23:0] fr_ad [64];

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + 11) % 256);
    end

    always @(negedge clk) begin
        if (ce_q === 1'b1 && ce_n === 1'b0) begin
            bcnt = 0; nby = 0; opc = '0; fa = '0;
        end
        if (ce_n === 1'b0 && sck_q === 1'b0 && sck === 1'b1) begin
            sh = {sh[6:0], si};
            bcnt++;
            if (bcnt % 8 == 0) begin
                nby++;
                if (nby == 1) opc = sh;
                else if (nby <= 4) begin
                    fa = {fa[15:0], sh};
                    if (nby == 4) rp = fa[5:0];
                end else if (nby == 5) pdat = sh;
            end
        end
        if (ce_n === 1'b0 && sck_q === 1'b1 && sck === 1'b0) begin
            if (bcnt % 8 == 0) begin
                if (opc == 8'h03 && nby >= 4) begin
                    outb = mem[rp];
                    rp = rp + 1'b1;
                end else if (opc == 8'h05 && nby == 1) begin
                    outb = {7'd0, (busy_left > 0)};
                end else begin
                    outb = 8'h00;
                end
            end
            so_r = outb[7];
            outb = {outb[6:0], 1'b0};
        end
        if (ce_q === 1'b0 && ce_n === 1'b1) begin
            fr_op[fr_n % 64] = opc;
            fr_nb[fr_n % 64] = nby;
            fr_ad[fr_n % 64] = fa;
            fr_n++;
            if (opc == 8'h06 && nby == 1) wel = 1'b1;
            if (opc == 8'h02 && nby == 5 && wel) begin
                mem[fa[5:0]] = pdat;
                wel = 1'b0;
                busy_left = busy_init;
            end
            if (opc == 8'h05 && nby == 2 && busy_left > 0) busy_left--;
        end
        ce_q = ce_n;
        sck_q = sck;
    end

    // ---------------- interface monitors
    logic si_q = 1'b0;
    int   mode_viol = 0;
    int   hp_viol = 0;
    int   hi_run = 0;
    int   gap_run = 0;
    int   min_gap = 1000000;
    bit   seen_low = 1'b0;
    int   stall_viol = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sck === 1'b1 && si !== si_q) mode_viol++;
            if (sck === 1'b1) hi_run++;
            else if (hi_run > 0) begin
                if (hi_run != CLK_DIV) hp_viol++;
                hi_run = 0;
            end
            if (ce_n === 1'b0) begin
                if (gap_run > 0 && gap_run < min_gap) min_gap = gap_run;
                gap_run = 0;
                seen_low = 1'b1;
            end else if (seen_low) begin
                gap_run++;
            end
            if (done === 1'b1 && seen_low) begin
                if (gap_run < min_gap) min_gap = gap_run;
                gap_run = 0;
                seen_low = 1'b0;
            end
            if (rd_valid === 1'b1 && sck === 1'b1) stall_viol++;
        end
        si_q = si;
    end

    // ---------------- read consumer
    int         rmode = 0;
    int         cyc = 0;
    int         vhold = 0;
    logic [7:0] got [256];
    int         ngot = 0;

    always @(negedge clk) begin
        cyc++;
        if (rd_valid === 1'b1) vhold++; else vhold = 0;
        case (rmode)
            0:       rd_ready = 1'b1;
            1:       rd_ready = (cyc % 3 == 0);
            default: rd_ready = (vhold >= 20);
        endcase
        if (rd_valid === 1'b1 && rd_ready) begin
            got[ngot % 256] = rd_data;
            ngot++;
        end
    end

    // ---------------- command tasks
    task automatic issue(input bit op, input logic [23:0] a, input int len,
                         input logic [7:0] wd, input int lim, output bit e);
        int waitc;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_addr = a;
        cmd_len = 16'(len);
        cmd_wdata = wd;
        cmd_poll_limit = 16'(lim);
        while (cmd_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R9", "cmd_ready after accept", cmd_ready, 0);
        waitc = 0;
        while (done !== 1'b1 && waitc < 100000) begin
            @(negedge clk);
            waitc++;
        end
        chk(done == 1'b1, "R9", "done seen", done, 1);
        e = err;
        @(negedge clk);
        chk(done == 1'b0 && err == 1'b0, "R9", "done single pulse", done, 0);
    endtask

    task automatic do_read(input logic [23:0] a, input int len);
        int f0 = fr_n;
        int g0 = ngot;
        bit e;
        int bad = 0;
        issue(1'b0, a, len, 8'h00, 0, e);
        chk(ngot - g0 == len, "R3", "read byte count", ngot - g0, len);
        for (int k = 0; k < len; k++) begin
            int ea = (int'(a[5:0]) + k) % 64;
            chk(got[(g0 + k) % 256] == mem[ea], "R3", "read data",
                got[(g0 + k) % 256], mem[ea]);
        end
        chk(fr_n - f0 == 1, "R3", "read frame count", fr_n - f0, 1);
        if (fr_op[f0 % 64] != 8'h03) bad++;
        if (fr_nb[f0 % 64] != 4 + len) bad++;
        if (fr_ad[f0 % 64] != a) bad++;
        chk(bad == 0, "R3", "read frame opcode/length/address",
            fr_nb[f0 % 64], 4 + len);
        chk(e == 1'b0, "R3", "read err", e, 0);
    endtask

    task automatic do_prog(input logic [23:0] a, input logic [7:0] d,
                           input int busyn, input int lim, input bit exp_err);
        int f0;
        int polls;
        int bad = 0;
        bit e;
        busy_init = busyn;
        f0 = fr_n;
        polls = exp_err ? ((lim < 1) ? 1 : lim) : busyn + 1;
        issue(1'b1, a, 0, d, lim, e);
        chk(e == exp_err, exp_err ? "R7" : "R6", "err flag", e, exp_err);
        chk(fr_n - f0 == 2 + polls, exp_err ? "R7" : "R6", "frame count",
            fr_n - f0, 2 + polls);
        chk(fr_op[f0 % 64] == 8'h06 && fr_nb[f0 % 64] == 1, "R5",
            "write-enable frame", fr_op[f0 % 64], 8'h06);
        chk(fr_op[(f0 + 1) % 64] == 8'h02 && fr_nb[(f0 + 1) % 64] == 5 &&
            fr_ad[(f0 + 1) % 64] == a, "R5", "program frame",
            fr_nb[(f0 + 1) % 64], 5);
        for (int p = 0; p < polls; p++) begin
            if (fr_op[(f0 + 2 + p) % 64] != 8'h05 || fr_nb[(f0 + 2 + p) % 64] != 2)
                bad++;
        end
        chk(bad == 0, "R6", "status frames 05h + one byte", bad, 0);
        chk(mem[a[5:0]] == d, "R5", "programmed byte", mem[a[5:0]], d);
    endtask

    // ---------------- watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // ---------------- main sequence
    initial begin
        logic [23:0] starts [3];
        starts[0] = 24'h000000;
        starts[1] = 24'hA51209;
        starts[2] = 24'h7F00FD;
        repeat (4) @(negedge clk);
        // R1: values under reset
        chk(ce_n == 1'b1, "R1", "ce_n in reset", ce_n, 1);
        chk(sck == 1'b0, "R1", "sck in reset", sck, 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready in reset", cmd_ready, 1);
        chk(rd_valid == 1'b0 && done == 1'b0 && err == 1'b0, "R1",
            "rd_valid/done/err in reset", rd_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ce_n == 1'b1 && sck == 1'b0 && cmd_ready == 1'b1, "R1",
            "idle after reset", ce_n, 1);

        // R3 / R4: read sweep over consumer patterns, starts and lengths
        for (int m = 0; m < 3; m++) begin
            rmode = m;
            for (int s = 0; s < 3; s++) begin
                for (int len = 0; len <= 6; len++) begin
                    do_read(starts[s], len);
                end
            end
        end
        rmode = 2;
        do_read(24'h12343C, 10);
        rmode = 0;

        // R5 / R6 / R7: program with various busy lengths and poll limits
        do_prog(24'h000105, 8'h5A, 3, 10, 1'b0);
        do_prog(24'h00AB22, 8'hC3, 0, 1, 1'b0);
        do_prog(24'h3F0010, 8'h96, 4, 5, 1'b0);
        do_prog(24'h000030, 8'h11, 100, 5, 1'b1);
        do_prog(24'h000031, 8'h22, 100, 0, 1'b1);
        do_read(24'h000104, 3);

        // R2 / R4 / R8: aggregate interface observations
        chk(mode_viol == 0, "R2", "si moved while sck high", mode_viol, 0);
        chk(hp_viol == 0, "R2", "sck high phase length", hp_viol, 0);
        chk(min_gap >= GAP_MIN, "R8", "minimum ce_n high time", min_gap, GAP_MIN);
        chk(stall_viol == 0, "R4", "sck high while byte held", stall_viol, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule